// File: doc/BRIEF.md
# Serial Flash Transaction Sequencer

This block executes one complete serial flash transaction from a handful of configuration words. A transaction is built from up to four phases that always run in a fixed order: an 8-bit opcode, an address of one to four bytes, a run of dummy clocks, and a data transfer either out of or into the block. Each phase has its own enable and its own lane-width code, selecting one, two or four data lanes. Phases that are disabled, and dummy or data phases whose length is zero, take no clocks at all.

Software fills the configuration words and, for writes, the byte buffer. It then writes the request bit. The sequencer pulls chip select low, clocks the enabled phases in SPI mode 0 with the most significant bit first, releases chip select, and raises a finish flag. When a data-in phase ran, it also raises a data-updated flag, and the received bytes sit in the buffer starting at index 0. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `spif_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, io_oe is 0, and word 0 (reg_addr 0) reads as zero.
- R2: Writing word 0 with bit 31 set while idle starts a transaction. cs_n falls while sclk is low, sclk rises only while cs_n is low, and cs_n returns high after the last bit, with sclk low.
- R3: The phases run in the order opcode, address, dummy, data. The enables are word 1 bit 10 (opcode, whose value is word 1 [7:0]), word 1 bit 16 (address), word 1 bit 28 (dummy), word 2 bit 12 (data out) and word 2 bit 28 (data in). A disabled phase produces no sclk cycles, so an opcode-only transaction on one lane is exactly 8 clocks.
- R4: The lane codes are word 1 [9:8] (opcode), [15:14] (address) and [27:26] (dummy), and word 2 [11:10] (out) and [27:26] (in). Code 0 selects 1 lane, code 1 selects 2 lanes and code 2 selects 4 lanes. Bits are sent MSB first, and in each clock the highest lane in use carries the most significant bit. With one lane, output is on io lane 0 and input on io lane 1. io_oe is 0001, 0011 or 1111 while the block drives, and 0000 otherwise.
- R5: Word 1 [13:12] holds the address byte count minus one. The phase sends the low-order bytes of word 3, most significant of them first.
- R6: The dummy phase lasts word 1 [25:20] sclk cycles, with io_oe equal to 0. A count of 0 skips the phase.
- R7: Data out sends word 2 [9:0] bytes from buffer indexes 0 upward. A length above 512 is limited to 512 bytes.
- R8: Data in samples the lanes at each rising sclk edge and stores word 2 [25:16] bytes into the buffer from index 0 upward.
- R9: When cs_n has returned high, word 0 bit 30 (finish) reads 1. Word 0 bit 0 (data updated) reads 1 only if a data-in phase ran.
- R10: A new request clears both flags. A request written while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration word write strobe |
| reg_addr | input | 2 | Configuration word index |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration read data for reg_addr |
| buf_we | input | 1 | Buffer byte write strobe (ignored while busy) |
| buf_addr | input | $clog2(BUF_BYTES) | Buffer byte index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer byte at buf_addr |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench targets the points where phases meet. An opcode-only transaction with address and dummy fields loaded but disabled would show extra clocks if the skip logic leaked. Mixed lane widths inside one transaction would show swapped or doubled bits if the shift step or lane order were wrong. A data-in phase right after dummy clocks would shift the received bytes by a lane group if the sample edge or the byte boundary were off. Further cases cover a length above the buffer size, which would run past 512 bytes without the limit, a second request during a busy transaction, which would restart the frame, and the flag clearing on a new request, which would otherwise leave a stale finish reading.

// File: rtl/spif_pkg.sv
package spif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DOUT, ST_DIN, ST_TAIL
    } phase_e;

    typedef struct packed {
        logic        cmd_en;
        logic [1:0]  cmd_mode;
        logic [7:0]  opcode;
        logic        addr_en;
        logic [1:0]  addr_mode;
        logic [1:0]  addr_nb_m1;
        logic        dum_en;
        logic [1:0]  dum_mode;
        logic [5:0]  dum_cyc;
        logic        dout_en;
        logic [1:0]  dout_mode;
        logic [9:0]  dout_len;
        logic        din_en;
        logic [1:0]  din_mode;
        logic [9:0]  din_len;
        logic [31:0] addr;
    } xfer_cfg_t;

    // log2 of lane count; the spare code falls back to four lanes
    function automatic logic [1:0] lane_lg(input logic [1:0] mode);
        return (mode == 2'd0) ? 2'd0 : (mode == 2'd1) ? 2'd1 : 2'd2;
    endfunction

    // first enabled, non-empty phase strictly after cur
    function automatic phase_e next_phase(input phase_e cur, input xfer_cfg_t c);
        phase_e n;
        n = ST_TAIL;
        if (cur inside {ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY}) begin
            if (c.dout_en && c.dout_len != 10'd0)
                n = ST_DOUT;
            else if (c.din_en && c.din_len != 10'd0)
                n = ST_DIN;
        end
        if ((cur inside {ST_IDLE, ST_CMD, ST_ADDR}) && c.dum_en && c.dum_cyc != 6'd0)
            n = ST_DUMMY;
        if ((cur inside {ST_IDLE, ST_CMD}) && c.addr_en)
            n = ST_ADDR;
        if (cur == ST_IDLE && c.cmd_en)
            n = ST_CMD;
        return n;
    endfunction

endpackage

// File: rtl/spif_regs.sv
module spif_regs
    import spif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        busy,
    input  logic        done,
    input  logic        done_read,
    output logic        start,
    output logic        fin,
    output xfer_cfg_t   cfg
);
    logic [31:0] w1_q, w2_q, a_q;
    logic        fin_q, upd_q;

    assign start = we && addr == 2'd0 && wdata[31] && !busy;
    assign fin   = fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            w1_q  <= '0;
            w2_q  <= '0;
            a_q   <= '0;
            fin_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            if (we) begin
                case (addr)
                    2'd1:    w1_q <= wdata;
                    2'd2:    w2_q <= wdata;
                    2'd3:    a_q  <= wdata;
                    default: ;
                endcase
            end
            if (start) begin
                fin_q <= 1'b0;
                upd_q <= 1'b0;
            end else if (done) begin
                fin_q <= 1'b1;
                upd_q <= done_read;
            end
        end
    end

    always_comb begin
        cfg.opcode     = w1_q[7:0];
        cfg.cmd_mode   = w1_q[9:8];
        cfg.cmd_en     = w1_q[10];
        cfg.addr_nb_m1 = w1_q[13:12];
        cfg.addr_mode  = w1_q[15:14];
        cfg.addr_en    = w1_q[16];
        cfg.dum_cyc    = w1_q[25:20];
        cfg.dum_mode   = w1_q[27:26];
        cfg.dum_en     = w1_q[28];
        cfg.dout_len   = w2_q[9:0];
        cfg.dout_mode  = w2_q[11:10];
        cfg.dout_en    = w2_q[12];
        cfg.din_len    = w2_q[25:16];
        cfg.din_mode   = w2_q[27:26];
        cfg.din_en     = w2_q[28];
        cfg.addr       = a_q;
    end

    always_comb begin
        case (addr)
            2'd0:    rdata = {1'b0, fin_q, 29'd0, upd_q};
            2'd1:    rdata = w1_q;
            2'd2:    rdata = w2_q;
            default: rdata = a_q;
        endcase
    end

endmodule

// File: rtl/spif_buf.sv
module spif_buf #(
    parameter int BYTES = 512,
    localparam int AW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] a_addr,
    output logic [7:0]    a_data,
    input  logic [AW-1:0] b_addr,
    output logic [7:0]    b_data
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];

endmodule

// File: rtl/spif_engine.sv
module spif_engine
    import spif_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int BUF_BYTES = 512,
    localparam int BAW = $clog2(BUF_BYTES),
    localparam int DW  = $clog2(HALF_DIV + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  xfer_cfg_t      cfg,
    input  logic [3:0]     io_in,
    input  logic [7:0]     rd_data,
    output logic [BAW-1:0] rd_addr,
    output logic           wr_en,
    output logic [BAW-1:0] wr_addr,
    output logic [7:0]     wr_data,
    output logic           sclk,
    output logic           cs_n,
    output logic [3:0]     io_out,
    output logic [3:0]     io_oe,
    output logic           busy,
    output logic           done,
    output logic           done_read
);
    phase_e         ph_q, nxt_ph;
    logic           sclk_q, cs_n_q, rd_q, done_q, done_rd_q;
    logic [DW-1:0]  div_q;
    logic [6:0]     cyc_q;
    logic [10:0]    bytes_q;
    logic [BAW-1:0] ptr_q;
    logic [31:0]    sh_q;
    logic [7:0]     rx_q, rx_nxt;
    logic [1:0]     lg_q;

    logic [1:0]  ld_lg;
    logic [6:0]  ld_cyc;
    logic [31:0] ld_sh;
    logic [10:0] ld_bytes;

    logic tick, unit_end, more_bytes, fall, shifting;

    assign shifting   = ph_q inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DOUT, ST_DIN};
    assign tick       = div_q == DW'(HALF_DIV - 1);
    assign unit_end   = cyc_q == 7'd1;
    assign more_bytes = (ph_q inside {ST_DOUT, ST_DIN}) && bytes_q > 11'd1;
    assign fall       = shifting && tick && sclk_q;
    assign nxt_ph     = next_phase(ph_q, cfg);
    assign rd_addr    = (ph_q == ST_IDLE) ? '0 : ptr_q;

    // what a phase looks like when it is entered
    always_comb begin
        ld_lg    = 2'd0;
        ld_cyc   = 7'd8;
        ld_sh    = '0;
        ld_bytes = 11'd0;
        case (nxt_ph)
            ST_CMD: begin
                ld_lg  = lane_lg(cfg.cmd_mode);
                ld_cyc = 7'd8 >> ld_lg;
                ld_sh  = {cfg.opcode, 24'd0};
            end
            ST_ADDR: begin
                ld_lg  = lane_lg(cfg.addr_mode);
                ld_cyc = 7'((7'(cfg.addr_nb_m1) + 7'd1) << (2'd3 - ld_lg));
                ld_sh  = cfg.addr << (6'd8 * (6'd3 - 6'(cfg.addr_nb_m1)));
            end
            ST_DUMMY: begin
                ld_lg  = lane_lg(cfg.dum_mode);
                ld_cyc = 7'(cfg.dum_cyc);
            end
            ST_DOUT: begin
                ld_lg    = lane_lg(cfg.dout_mode);
                ld_cyc   = 7'd8 >> ld_lg;
                ld_sh    = {rd_data, 24'd0};
                ld_bytes = (11'(cfg.dout_len) > 11'(BUF_BYTES)) ? 11'(BUF_BYTES)
                                                                  : 11'(cfg.dout_len);
            end
            ST_DIN: begin
                ld_lg    = lane_lg(cfg.din_mode);
                ld_cyc   = 7'd8 >> ld_lg;
                ld_bytes = (11'(cfg.din_len) > 11'(BUF_BYTES)) ? 11'(BUF_BYTES)
                                                                 : 11'(cfg.din_len);
            end
            default: ;
        endcase
    end

    always_comb begin
        case (lg_q)
            2'd0:    rx_nxt = {rx_q[6:0], io_in[1]};
            2'd1:    rx_nxt = {rx_q[5:0], io_in[1:0]};
            default: rx_nxt = {rx_q[3:0], io_in[3:0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= ST_IDLE;
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            div_q     <= '0;
            cyc_q     <= '0;
            bytes_q   <= '0;
            ptr_q     <= '0;
            sh_q      <= '0;
            rx_q      <= '0;
            lg_q      <= '0;
            rd_q      <= 1'b0;
            done_q    <= 1'b0;
            done_rd_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                ST_IDLE: begin
                    if (start) begin
                        cs_n_q  <= 1'b0;
                        sclk_q  <= 1'b0;
                        div_q   <= '0;
                        ph_q    <= nxt_ph;
                        lg_q    <= ld_lg;
                        cyc_q   <= ld_cyc;
                        sh_q    <= ld_sh;
                        bytes_q <= ld_bytes;
                        ptr_q   <= (nxt_ph == ST_DOUT) ? BAW'(1) : '0;
                        rd_q    <= nxt_ph == ST_DIN;
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        div_q     <= '0;
                        cs_n_q    <= 1'b1;
                        ph_q      <= ST_IDLE;
                        done_q    <= 1'b1;
                        done_rd_q <= rd_q;
                    end else begin
                        div_q <= div_q + DW'(1);
                    end
                end
                default: begin
                    div_q <= tick ? '0 : div_q + DW'(1);
                    if (tick && !sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= rx_nxt;
                    end else if (tick) begin
                        sclk_q <= 1'b0;
                        if (!unit_end) begin
                            cyc_q <= cyc_q - 7'd1;
                            sh_q  <= sh_q << (6'd1 << lg_q);
                        end else if (more_bytes) begin
                            bytes_q <= bytes_q - 11'd1;
                            cyc_q   <= 7'd8 >> lg_q;
                            ptr_q   <= ptr_q + BAW'(1);
                            sh_q    <= {rd_data, 24'd0};
                        end else begin
                            ph_q    <= nxt_ph;
                            lg_q    <= ld_lg;
                            cyc_q   <= ld_cyc;
                            sh_q    <= ld_sh;
                            bytes_q <= ld_bytes;
                            rd_q    <= rd_q | (nxt_ph == ST_DIN);
                            if (nxt_ph == ST_DOUT || ph_q == ST_DIN)
                                ptr_q <= ptr_q + BAW'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign wr_en     = fall && ph_q == ST_DIN && unit_end;
    assign wr_addr   = ptr_q;
    assign wr_data   = rx_q;
    assign sclk      = sclk_q;
    assign cs_n      = cs_n_q;
    assign busy      = ph_q != ST_IDLE;
    assign done      = done_q;
    assign done_read = done_rd_q;

    always_comb begin
        case (lg_q)
            2'd0:    io_out = {3'd0, sh_q[31]};
            2'd1:    io_out = {2'd0, sh_q[31:30]};
            default: io_out = sh_q[31:28];
        endcase
        if (ph_q inside {ST_CMD, ST_ADDR, ST_DOUT})
            io_oe = (lg_q == 2'd0) ? 4'b0001 : (lg_q == 2'd1) ? 4'b0011 : 4'b1111;
        else
            io_oe = 4'b0000;
        if (io_oe == 4'b0000)
            io_out = 4'b0000;
    end

endmodule

// File: rtl/spif_seq.sv
module spif_seq
    import spif_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int BUF_BYTES = 512
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_we,
    input  logic [1:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         buf_we,
    input  logic [$clog2(BUF_BYTES)-1:0] buf_addr,
    input  logic [7:0]                   buf_wdata,
    output logic [7:0]                   buf_rdata,
    output logic                         sclk,
    output logic                         cs_n,
    output logic [3:0]                   io_out,
    output logic [3:0]                   io_oe,
    input  logic [3:0]                   io_in
);
    localparam int BAW = $clog2(BUF_BYTES);

    xfer_cfg_t      cfg;
    logic           start_w, busy_w, done_w, done_rd_w, fin_w;
    logic           eng_we;
    logic [BAW-1:0] eng_waddr, eng_raddr;
    logic [7:0]     eng_wdata, eng_rdata;
    logic           m_we;
    logic [BAW-1:0] m_waddr;
    logic [7:0]     m_wdata;

    spif_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy_w), .done(done_w), .done_read(done_rd_w),
        .start(start_w), .fin(fin_w), .cfg(cfg)
    );

    // the host owns the buffer write port only while idle
    assign m_we    = busy_w ? eng_we    : buf_we;
    assign m_waddr = busy_w ? eng_waddr : buf_addr;
    assign m_wdata = busy_w ? eng_wdata : buf_wdata;

    spif_buf #(.BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
        .a_addr(buf_addr), .a_data(buf_rdata),
        .b_addr(eng_raddr), .b_data(eng_rdata)
    );

    spif_engine #(.HALF_DIV(HALF_DIV), .BUF_BYTES(BUF_BYTES)) u_eng (
        .clk(clk), .rst(rst), .start(start_w), .cfg(cfg), .io_in(io_in),
        .rd_data(eng_rdata), .rd_addr(eng_raddr),
        .wr_en(eng_we), .wr_addr(eng_waddr), .wr_data(eng_wdata),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
        .busy(busy_w), .done(done_w), .done_read(done_rd_w)
    );

endmodule

// File: rtl/spif_seq_chk.sv
module spif_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic       cs_n,
    input logic [3:0] io_oe,
    input logic       fin,
    input logic       busy
);
    // R2: serial clock pulses only inside a chip-select frame
    assert_sclk_framed_R2: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);

    // R2: frame opens with the clock at its idle level
    assert_cs_fall_idle_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    // R2: frame closes with the clock at its idle level
    assert_cs_rise_idle_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> !sclk);

    // R4: only the legal lane-enable patterns appear
    assert_oe_legal_R4: assert property (@(posedge clk) disable iff (rst)
        io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111);

    // R4: lanes are driven only while selected
    assert_oe_framed_R4: assert property (@(posedge clk) disable iff (rst)
        (io_oe != 4'b0000) |-> !cs_n);

    // R9: finish is reported only once chip select is released
    assert_finish_after_cs_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fin) |-> cs_n);

    // R10: a starting transaction never shows a stale finish flag
    assert_flags_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !fin);
endmodule

bind spif_seq spif_seq_chk u_chk (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .io_oe(io_oe),
    .fin(fin_w), .busy(busy_w)
);

// File: tb/sim_spif_seq.sv
module sim_spif_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        buf_we = 1'b0;
    logic [8:0]  buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic [7:0]  buf_rdata;
    logic        sclk, cs_n;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'd0;

    always #10 clk = ~clk;

    spif_seq u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int checks = 0;
    int fails  = 0;

    logic [3:0] r_out [2048];
    logic [3:0] r_oe  [2048];
    logic [3:0] e_out [2048];
    logic [3:0] e_oe  [2048];
    int ecnt = 0, xcnt = 0, cs_falls = 0, unframed = 0;
    int din_pre = 1 << 30;
    int din_lg  = 0;

    always @(posedge sclk) begin
        if (ecnt < 2048) begin
            r_out[ecnt] = io_out;
            r_oe[ecnt]  = io_oe;
        end
        if (cs_n) unframed++;
        ecnt++;
    end

    always @(negedge cs_n) cs_falls++;

    function automatic logic [7:0] din_byte(input int k);
        return 8'h3C ^ 8'(k * 29);
    endfunction

    // flash model: present the lane group for the next rising edge
    function automatic logic [3:0] din_group(input int e);
        int k, bp;
        logic [7:0] s;
        if (e < din_pre) return 4'd0;
        k  = e - din_pre;
        bp = k * (1 << din_lg);
        s  = din_byte(bp / 8) << (bp % 8);
        case (din_lg)
            0:       return {2'b00, s[7], 1'b0};
            1:       return {2'b00, s[7:6]};
            default: return s[7:4];
        endcase
    endfunction

    always @(negedge sclk or negedge cs_n) io_in = din_group(ecnt);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr_buf(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 9'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic rd_buf(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = 9'(a);
        #1 d = buf_rdata;
    endtask

    task automatic push(input logic [31:0] v, input int nbits, input int lg, input bit drv);
        for (int i = 0; i < nbits; i += (1 << lg)) begin
            logic [31:0] s;
            logic [3:0]  o, oe;
            s = v << i;
            case (lg)
                0:       begin o = {3'b000, s[31]};  oe = 4'b0001; end
                1:       begin o = {2'b00, s[31:30]}; oe = 4'b0011; end
                default: begin o = s[31:28];          oe = 4'b1111; end
            endcase
            e_out[xcnt] = drv ? o : 4'd0;
            e_oe[xcnt]  = drv ? oe : 4'd0;
            xcnt++;
        end
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            rd_reg(2'd0, v);
            n++;
        end while (!v[30] && n < 50000);
        chk(v[30] == 1'b1, req, v[30], 1);
        chk(cs_n == 1'b1, "R2 cs_n released", cs_n, 1);
    endtask

    task automatic launch(input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] a);
        wr_reg(2'd1, w1);
        wr_reg(2'd2, w2);
        wr_reg(2'd3, a);
        ecnt = 0; cs_falls = 0; unframed = 0;
        wr_reg(2'd0, 32'h8000_0000);
    endtask

    task automatic cmp_stream(input string req);
        int bad;
        bad = -1;
        chk(ecnt == xcnt, {req, " clock count"}, ecnt, xcnt);
        for (int i = 0; i < xcnt && i < 2048; i++) begin
            if (bad < 0 && (r_oe[i] != e_oe[i] || (r_out[i] & e_oe[i]) != (e_out[i] & e_oe[i])))
                bad = i;
        end
        if (bad >= 0)
            chk(1'b0, {req, " lane stream"}, {r_oe[bad], r_out[bad]}, {e_oe[bad], e_out[bad]});
        else
            chk(1'b1, {req, " lane stream"}, 0, 0);
        chk(cs_falls == 1 && unframed == 0, "R2 single framed transaction", cs_falls, 1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(2'd0, v);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(io_oe == 4'd0, "R1 io_oe", io_oe, 0);
        chk(v == 32'd0, "R1 word0", v, 0);
    endtask

    // R3: address and dummy fields loaded but disabled
    task automatic t_opcode_only;
        logic [31:0] v;
        xcnt = 0;
        push({8'h06, 24'd0}, 8, 0, 1);
        launch(32'h0050_3406, 32'd0, 32'hFFFF_FFFF);
        wait_done("R9 finish after opcode only");
        cmp_stream("R3 opcode only");
        rd_reg(2'd0, v);
        chk(v[0] == 1'b0, "R9 no data-updated without data in", v[0], 0);
    endtask

    // R4 R5 R7: one-lane opcode and address, four-lane data out
    task automatic t_write_quad;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'hC3, 8'hF4};
        xcnt = 0;
        for (int i = 0; i < 4; i++) wr_buf(i, d[i]);
        push({8'h32, 24'd0}, 8, 0, 1);
        push({24'hABCDEF, 8'd0}, 24, 0, 1);
        for (int i = 0; i < 4; i++) push({d[i], 24'd0}, 8, 2, 1);
        launch(32'h0001_2432, 32'h0000_1804, 32'h12AB_CDEF);
        wait_done("R9 finish after write");
        cmp_stream("R7 R5 R4 quad write");
    endtask

    // R6 R8: four-lane address, dummy and data in
    task automatic t_read_quad;
        logic [7:0]  b;
        logic [31:0] v;
        xcnt = 0;
        din_pre = 8 + 6 + 6; din_lg = 2;
        push({8'hEB, 24'd0}, 8, 0, 1);
        push({24'h345678, 8'd0}, 24, 2, 1);
        push(32'd0, 6 * 4, 2, 0);
        push(32'd0, 5 * 8, 2, 0);
        launch(32'h1861_A4EB, 32'h1805_0000, 32'h0034_5678);
        wait_done("R9 finish after quad read");
        cmp_stream("R6 R8 quad read");
        for (int k = 0; k < 5; k++) begin
            rd_buf(k, b);
            chk(b == din_byte(k), "R8 quad read byte", b, din_byte(k));
        end
        rd_reg(2'd0, v);
        chk(v[0] == 1'b1, "R9 data-updated after read", v[0], 1);
        din_pre = 1 << 30;
    endtask

    // R4 R5: two-lane four-byte address and data in
    task automatic t_read_dual;
        logic [7:0] b;
        xcnt = 0;
        din_pre = 8 + 16 + 8; din_lg = 1;
        push({8'h3B, 24'd0}, 8, 0, 1);
        push(32'h89AB_CDEF, 32, 1, 1);
        push(32'd0, 8, 0, 0);
        push(32'd0, 3 * 8, 1, 0);
        launch(32'h1081_743B, 32'h1403_0000, 32'h89AB_CDEF);
        wait_done("R9 finish after dual read");
        cmp_stream("R4 R5 dual read");
        for (int k = 0; k < 3; k++) begin
            rd_buf(k, b);
            chk(b == din_byte(k), "R8 dual read byte", b, din_byte(k));
        end
        din_pre = 1 << 30;
    endtask

    // R4 R8: single-lane input taken from lane 1
    task automatic t_read_single;
        logic [7:0] b;
        xcnt = 0;
        din_pre = 8; din_lg = 0;
        push({8'h03, 24'd0}, 8, 0, 1);
        push(32'd0, 16, 0, 0);
        launch(32'h0000_0403, 32'h1002_0000, 32'd0);
        wait_done("R9 finish after single read");
        cmp_stream("R4 single read");
        for (int k = 0; k < 2; k++) begin
            rd_buf(k, b);
            chk(b == din_byte(k), "R8 single read byte", b, din_byte(k));
        end
        din_pre = 1 << 30;
    endtask

    // R10: flags clear on a new request
    task automatic t_flag_clear;
        logic [31:0] v;
        rd_reg(2'd0, v);
        chk(v[0] == 1'b1 && v[30] == 1'b1, "R10 flags before new request", v, 32'h4000_0001);
        xcnt = 0;
        push({8'h05, 24'd0}, 8, 0, 1);
        launch(32'h0000_0405, 32'd0, 32'd0);
        rd_reg(2'd0, v);
        chk(v == 32'd0, "R10 flags cleared by request", v, 0);
        wait_done("R9 finish after flag clear");
        rd_reg(2'd0, v);
        chk(v[0] == 1'b0, "R10 data-updated stays clear", v[0], 0);
    endtask

    // R10: request during a busy transaction is ignored
    task automatic t_busy_request;
        logic [31:0] v;
        xcnt = 0;
        push({8'hA5, 24'd0}, 8, 0, 1);
        launch(32'h0000_04A5, 32'd0, 32'd0);
        repeat (10) @(negedge clk);
        wr_reg(2'd0, 32'h8000_0000);
        wait_done("R9 finish with busy request");
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b1, "R10 no second frame", cs_n, 1);
        cmp_stream("R10 busy request ignored");
        rd_reg(2'd0, v);
        chk(v[30] == 1'b1, "R10 finish kept", v[30], 1);
    endtask

    // R7: length above buffer size limited to 512 bytes
    task automatic t_clamp;
        launch(32'd0, 32'h0000_1BFF, 32'd0);
        wait_done("R9 finish after long write");
        chk(ecnt == 1024, "R7 length limit clocks", ecnt, 1024);
        chk(cs_falls == 1, "R2 one frame for long write", cs_falls, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_opcode_only();
        t_write_quad();
        t_read_quad();
        t_flag_clear();
        t_read_dual();
        t_read_single();
        t_busy_request();
        t_clamp();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule